// File: doc/BRIEF.md
# Isolated Gate Driver Control Sequencer

This block is the digital controller of a single-channel isolated gate driver. It decides, cycle by cycle, whether the output stage may follow the PWM input. It watches four things: a shared open-drain enable line, which a PWM controller and any number of drivers can each hold low; a primary undervoltage flag; a secondary undervoltage flag; and an over-temperature flag. The three flags come from comparators outside the block.

The block holds the enable line low while its own supply is starting up or a fault is present, so the line doubles as a readiness flag for the whole system. Once the line is high, the block arms the output only on the first rising edge of the input, so the output never begins with a runt pulse. It stretches every output level to a minimum width. It also asks the bias-transfer stage for a refresh pulse whenever the input stays at one level long enough that the isolated rails would otherwise droop.

All timer lengths are parameters counted in clock cycles. The defaults suit a 100 MHz clock: a 250 µs startup, a 100 ns minimum width and a 12 µs refresh interval.

Top module: `gdrv_seq`

## Requirements
- R1: While reset is asserted, out_pu is 0, out_pd is 1, en_pull_low is 1 and refresh_req is 0.
- R2: en_pull_low is 1 in the same cycle whenever pri_uv or ot_flag is 1 or the startup timer is running, and it is 0 otherwise. Neither sec_uv nor the level of the enable line affects it.
- R3: The startup timer counts START_CYC clock edges. It counts from reset release, or from the last clock edge that samples pri_uv high. en_pull_low falls in the cycle after the START_CYC-th edge with pri_uv low, and input changes during this interval never reach the output.
- R4: When the enable line reads low from any source, out_pu falls two cycles after the line falls, which is the synchronizer delay. While the line stays low, input changes are ignored.
- R5: After the block becomes enabled, out_pu stays 0 until the input rises, even if the input is already high. A rise sampled at clock edge k drives out_pu high from edge k+2.
- R6: sec_uv = 1 forces out_pu to 0 in the same cycle without pulling the enable line low. After sec_uv clears, the output waits for a new input rise.
- R7: pri_uv = 1 forces out_pu to 0 and en_pull_low to 1 in the same cycle.
- R8: Each output level lasts at least MIN_PW_CYC cycles while the block stays enabled. A change in input level sampled at edge k reaches the output at edge k+2 if the hold window has expired; otherwise it reaches the output at the end of that window.
- R9: An input pulse that begins and ends inside an output hold window never reaches the output.
- R10: While the enable line is high, the block is not pulling it low and the input is constant, refresh_req is a one-cycle pulse every REFRESH_CYC cycles.
- R11: An input level change sampled at edge k restarts the refresh interval, so the next pulse appears from edge k+REFRESH_CYC+2. No pulse appears while the line is low or the block pulls it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM input, asynchronous |
| en_line_in | input | 1 | Sampled level of the shared open-drain enable line, asynchronous |
| pri_uv | input | 1 | Primary supply undervoltage flag, synchronous |
| sec_uv | input | 1 | Secondary rail undervoltage flag, synchronous |
| ot_flag | input | 1 | Over-temperature flag, synchronous |
| en_pull_low | output | 1 | Request to pull the enable line low |
| out_pu | output | 1 | Output pull-up command |
| out_pd | output | 1 | Output pull-down command |
| refresh_req | output | 1 | One-cycle request to recharge the isolated rails |

## Verification
The hardest situation to reach is an input glitch that falls inside the minimum-width hold window and then reverts before the window closes. Producing it needs an output transition whose cycle is known exactly, followed by a one-cycle input pulse placed a set number of cycles later. The bench gets there by computing, from the two-stage synchronizer and the arming register, the edge at which each output change lands. It then schedules the glitch right after that edge. Refresh pulses are treated the same way: they are checked only at cycles worked out from the last input change or the last enable release.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

   // status flags from the analog comparators
   typedef struct packed {
      logic pri_uv;
      logic sec_uv;
      logic over_temp;
   } gdrv_flags_t;

   // flags that must hold the shared enable line low
   function automatic logic gdrv_line_fault(input gdrv_flags_t f);
      return f.pri_uv | f.over_temp;
   endfunction

endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gdrv_sync needs at least two stages");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("gdrv_sync needs a positive width");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gdrv_start_timer.sv
module gdrv_start_timer #(
   parameter int START_CYC = 25000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pri_uv,
   output logic busy
);
   generate
      if (START_CYC < 1) begin : g_bad_start
         $error("START_CYC must be at least one");
      end
   endgenerate

   localparam int CW = $clog2(START_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(START_CYC);

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= LOAD;
      else if (pri_uv)         remain <= LOAD;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);

   // R3: the first cycle after the supply recovers is still inside startup
   p_startup_rearm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pri_uv && $past(pri_uv)) |-> busy);
endmodule

// File: rtl/gdrv_out_gate.sv
module gdrv_out_gate #(
   parameter int MIN_PW_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_ok,
   input  logic pwm_lvl,
   input  logic pwm_rise,
   output logic drv
);
   generate
      if (MIN_PW_CYC < 1) begin : g_bad_pw
         $error("MIN_PW_CYC must be at least one");
      end
   endgenerate

   localparam int HW = (MIN_PW_CYC > 1) ? $clog2(MIN_PW_CYC) : 1;
   localparam logic [HW-1:0] HOLD_LOAD = HW'(MIN_PW_CYC - 1);

   logic          armed;
   logic [HW-1:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         drv   <= 1'b0;
         hold  <= '0;
      end else if (!run_ok) begin
         armed <= 1'b0;
         drv   <= 1'b0;
         hold  <= '0;
      end else if (!armed) begin
         if (pwm_rise) begin
            armed <= 1'b1;
            drv   <= 1'b1;
            hold  <= HOLD_LOAD;
         end
      end else if (hold != '0) begin
         hold <= hold - 1'b1;
      end else if (pwm_lvl != drv) begin
         drv  <= pwm_lvl;
         hold <= HOLD_LOAD;
      end
   end

   // R8: an enabled output level never changes before its hold window ends
   p_min_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_ok && $past(run_ok) && (drv != $past(drv))) |-> ($past(hold) == '0));
endmodule

// File: rtl/gdrv_refresh.sv
module gdrv_refresh #(
   parameter int REFRESH_CYC = 1200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic pwm_edge,
   output logic req
);
   generate
      if (REFRESH_CYC < 2) begin : g_bad_ref
         $error("REFRESH_CYC must be at least two");
      end
   endgenerate

   localparam int RW = $clog2(REFRESH_CYC);
   localparam logic [RW-1:0] RELOAD = RW'(REFRESH_CYC - 1);

   logic [RW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left <= RELOAD;
         req  <= 1'b0;
      end else if (!active || pwm_edge) begin
         left <= RELOAD;
         req  <= 1'b0;
      end else if (left == '0) begin
         left <= RELOAD;
         req  <= 1'b1;
      end else begin
         left <= left - 1'b1;
         req  <= 1'b0;
      end
   end

   // R10: each request lasts exactly one cycle
   p_refresh_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> !req);
   // R11: no request follows a standby cycle
   p_refresh_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(active) |-> !req);
endmodule

// File: rtl/gdrv_seq.sv
module gdrv_seq
   import gdrv_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int START_CYC   = 25000,
   parameter int MIN_PW_CYC  = 10,
   parameter int REFRESH_CYC = 1200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_in,
   input  logic en_line_in,
   input  logic pri_uv,
   input  logic sec_uv,
   input  logic ot_flag,
   output logic en_pull_low,
   output logic out_pu,
   output logic out_pd,
   output logic refresh_req
);
   gdrv_flags_t flags;
   logic [1:0]  sync_q;
   logic        pwm_s, en_s, pwm_d;
   logic        start_busy, run_ok, drv, line_up;

   assign flags = '{pri_uv: pri_uv, sec_uv: sec_uv, over_temp: ot_flag};

   gdrv_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d (pwm_in_en(pwm_in, en_line_in)),
      .q (sync_q)
   );

   function automatic logic [1:0] pwm_in_en(input logic p, input logic e);
      return {e, p};
   endfunction

   assign pwm_s = sync_q[0];
   assign en_s  = sync_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_d <= 1'b0;
      else        pwm_d <= pwm_s;
   end

   gdrv_start_timer #(.START_CYC(START_CYC)) u_timer (
      .clk (clk),
      .rst_n (rst_n),
      .pri_uv (flags.pri_uv),
      .busy (start_busy)
   );

   assign en_pull_low = gdrv_line_fault(flags) | start_busy;
   assign line_up     = en_s & ~en_pull_low;
   assign run_ok      = line_up & ~flags.sec_uv;

   gdrv_out_gate #(.MIN_PW_CYC(MIN_PW_CYC)) u_gate (
      .clk (clk),
      .rst_n (rst_n),
      .run_ok (run_ok),
      .pwm_lvl (pwm_s),
      .pwm_rise (pwm_s & ~pwm_d),
      .drv (drv)
   );

   assign out_pu = drv & run_ok;
   assign out_pd = ~out_pu;

   gdrv_refresh #(.REFRESH_CYC(REFRESH_CYC)) u_refresh (
      .clk (clk),
      .rst_n (rst_n),
      .active (line_up),
      .pwm_edge (pwm_s ^ pwm_d),
      .req (refresh_req)
   );

   // R7: primary undervoltage shuts the output and flags the line at once
   p_uv_shutdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pri_uv |-> (!out_pu && en_pull_low));
   // R4: a low enable line keeps the output off
   p_line_low_out_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |-> !out_pu);
   // R6: secondary undervoltage keeps the output off
   p_sec_uv_out_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sec_uv |-> !out_pu);
endmodule

// File: tb/gdrv_seq_tb_top.sv
module gdrv_seq_tb_top;
   localparam int S = 40;
   localparam int M = 4;
   localparam int F = 20;

   logic clk = 1'b0;
   logic rst_n, pwm_in, ctl_pull, pri_uv, sec_uv, ot_flag;
   logic en_pull_low, out_pu, out_pd, refresh_req;
   logic en_line;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      int    at;
      int    sig;
      bit    val;
      string tag;
   } exp_t;
   exp_t q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // open-drain line: low when anyone pulls
   assign en_line = ~(en_pull_low | ctl_pull);

   gdrv_seq #(.SYNC_STAGES(2), .START_CYC(S), .MIN_PW_CYC(M), .REFRESH_CYC(F)) dut_i (
      .clk (clk),
      .rst_n (rst_n),
      .pwm_in (pwm_in),
      .en_line_in (en_line),
      .pri_uv (pri_uv),
      .sec_uv (sec_uv),
      .ot_flag (ot_flag),
      .en_pull_low (en_pull_low),
      .out_pu (out_pu),
      .out_pd (out_pd),
      .refresh_req (refresh_req)
   );

   // sig: 0 out_pu, 1 out_pd, 2 en_pull_low, 3 refresh_req
   task automatic expect_at(input int c, input int sig, input bit v, input string tag);
      q.push_back('{at: c, sig: sig, val: v, tag: tag});
   endtask

   task automatic at(input int n);
      while (cyc != n) @(negedge clk);
   endtask

   function automatic bit pick(input int sig);
      case (sig)
         0:       return out_pu;
         1:       return out_pd;
         2:       return en_pull_low;
         default: return refresh_req;
      endcase
   endfunction

   function automatic string sname(input int sig);
      case (sig)
         0:       return "out_pu";
         1:       return "out_pd";
         2:       return "en_pull_low";
         default: return "refresh_req";
      endcase
   endfunction

   // monitor: compares scoreboard entries due in this cycle
   always begin
      @(negedge clk);
      #1;
      for (int i = q.size() - 1; i >= 0; i--) begin
         if (q[i].at == cyc) begin
            n_chk++;
            if (pick(q[i].sig) !== q[i].val) begin
               n_fail++;
               $display("FAIL %s cycle %0d %s: actual %b expected %b",
                        q[i].tag, cyc, sname(q[i].sig), pick(q[i].sig), q[i].val);
            end
            q.delete(i);
         end
      end
   end

   initial begin
      rst_n = 1'b0; pwm_in = 1'b0; ctl_pull = 1'b0;
      pri_uv = 1'b0; sec_uv = 1'b0; ot_flag = 1'b0;
      expect_at(2, 0, 1'b0, "R1");
      expect_at(2, 1, 1'b1, "R1");
      expect_at(2, 2, 1'b1, "R1");
      expect_at(2, 3, 1'b0, "R1");
      at(4); rst_n = 1'b1;
      expect_at(20, 2, 1'b1, "R2");
      expect_at(4 + S - 1, 2, 1'b1, "R3");
      expect_at(4 + S, 2, 1'b0, "R3");
      at(10); pwm_in = 1'b1;
      expect_at(4 + S - 2, 0, 1'b0, "R3");
      expect_at(60, 0, 1'b0, "R5");
      expect_at(4 + S + F + 1, 3, 1'b0, "R10");
      expect_at(4 + S + F + 2, 3, 1'b1, "R10");
      expect_at(4 + S + F + 3, 3, 1'b0, "R10");
      expect_at(4 + S + 2 * F + 2, 3, 1'b1, "R10");
      at(90); pwm_in = 1'b0;
      at(100); pwm_in = 1'b1;
      expect_at(102, 0, 1'b0, "R5");
      expect_at(103, 0, 1'b1, "R5");
      expect_at(103, 1, 1'b0, "R5");
      expect_at(101 + F + 1, 3, 1'b0, "R11");
      expect_at(101 + F + 2, 3, 1'b1, "R11");
      // one-cycle low after hold expiry: stretched to M cycles
      at(130); pwm_in = 1'b0;
      at(131); pwm_in = 1'b1;
      expect_at(133, 0, 1'b0, "R8");
      expect_at(133 + M - 1, 0, 1'b0, "R8");
      expect_at(133 + M, 0, 1'b1, "R8");
      // glitch inside the new hold window
      at(137); pwm_in = 1'b0;
      at(138); pwm_in = 1'b1;
      expect_at(139, 0, 1'b1, "R9");
      expect_at(141, 0, 1'b1, "R9");
      expect_at(142, 0, 1'b1, "R9");
      at(150); pwm_in = 1'b0;
      expect_at(153, 0, 1'b0, "R8");
      // one-cycle high: stretched to M cycles
      at(160); pwm_in = 1'b1;
      at(161); pwm_in = 1'b0;
      expect_at(163, 0, 1'b1, "R8");
      expect_at(163 + M - 1, 0, 1'b1, "R8");
      expect_at(163 + M, 0, 1'b0, "R8");
      at(170); pwm_in = 1'b1;
      expect_at(173, 0, 1'b1, "R8");
      // external pull on the shared line
      at(180); ctl_pull = 1'b1;
      expect_at(181, 0, 1'b1, "R4");
      expect_at(182, 0, 1'b0, "R4");
      expect_at(185, 2, 1'b0, "R2");
      at(185); pwm_in = 1'b0;
      at(190); pwm_in = 1'b1;
      expect_at(195, 0, 1'b0, "R4");
      at(200); ctl_pull = 1'b0;
      expect_at(210, 0, 1'b0, "R5");
      at(212); pwm_in = 1'b0;
      at(216); pwm_in = 1'b1;
      expect_at(218, 0, 1'b0, "R5");
      expect_at(219, 0, 1'b1, "R5");
      // secondary undervoltage
      at(230); sec_uv = 1'b1;
      expect_at(230, 0, 1'b0, "R6");
      expect_at(230, 2, 1'b0, "R6");
      at(232); pwm_in = 1'b0;
      at(236); pwm_in = 1'b1;
      expect_at(240, 0, 1'b0, "R6");
      at(245); sec_uv = 1'b0;
      expect_at(250, 0, 1'b0, "R6");
      at(252); pwm_in = 1'b0;
      at(256); pwm_in = 1'b1;
      expect_at(259, 0, 1'b1, "R6");
      // over-temperature
      at(270); ot_flag = 1'b1;
      expect_at(270, 2, 1'b1, "R2");
      expect_at(270, 0, 1'b0, "R2");
      at(275); ot_flag = 1'b0;
      expect_at(275, 2, 1'b0, "R2");
      expect_at(280, 0, 1'b0, "R5");
      at(282); pwm_in = 1'b0;
      at(286); pwm_in = 1'b1;
      expect_at(289, 0, 1'b1, "R5");
      // primary undervoltage in operation, then restart
      at(295); pri_uv = 1'b1;
      expect_at(295, 0, 1'b0, "R7");
      expect_at(295, 2, 1'b1, "R7");
      at(300); pri_uv = 1'b0;
      expect_at(300 + S - 1, 2, 1'b1, "R3");
      expect_at(300 + S, 2, 1'b0, "R3");
      at(310); pwm_in = 1'b0;
      at(315); pwm_in = 1'b1;
      expect_at(330, 3, 1'b0, "R11");
      expect_at(338, 0, 1'b0, "R3");
      expect_at(350, 0, 1'b0, "R5");
      at(360);
      while (q.size() != 0) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule